// File: doc/BRIEF.md
# Single-Operand Four-Function ALU

This block is a purely combinational arithmetic-logic unit that works on one operand. A 2-bit function code picks one of four results: the bitwise complement of the operand, the operand plus one, the operand minus one, or the operand doubled. All results wrap modulo 2^WIDTH. A carry flag comes with each arithmetic result.

The three arithmetic functions share one ripple-carry adder. A selector picks the adder's second input: the constant one, the all-ones pattern (minus one in two's complement), or the operand itself. The adder's carry-in is held at zero. Each adder bit is a full-adder cell made of two half-adder cells and an OR gate. The final result comes from a 4-to-1 selector built from three 2-to-1 selectors. The block has no clock and no reset. Outputs follow the inputs through gates only.

Top module: `sel_alu`

## Requirements
- R1: With func = 2'b00 the result is the bitwise complement of the operand and carry is 0.
- R2: With func = 2'b01 the result is (operand + 1) mod 16, and carry is 1 exactly when the operand is 4'b1111.
- R3: With func = 2'b10 the result is (operand - 1) mod 16, and carry is 1 for every operand except 4'b0000. Carry set means no borrow.
- R4: With func = 2'b11 the result is (2 * operand) mod 16, and carry equals operand bit 3.
- R5: Results wrap at the word boundary: 4'b1111 incremented gives 4'b0000, 4'b0000 decremented gives 4'b1111, and 4'b1000 doubled gives 4'b0000.
- R6: Result and carry depend only on the present operand and func. They are valid in the same cycle the inputs change, with no register stage, and they do not depend on any earlier input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 4 | Operand (WIDTH bits) |
| func | input | 2 | Function code: 00 complement, 01 increment, 10 decrement, 11 double |
| res | output | 4 | Result (WIDTH bits) |
| carry | output | 1 | Adder carry-out for codes 01 to 11, zero for code 00 |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the inputs and the outputs. The bench changes the operand and function code just after a rising edge and reads res and carry at the next falling edge, half a period later, when the gate paths have settled. It applies all sixteen operands under each code, in an order that changes the code between vectors in one scenario. That ordering shows that no earlier input affects a result (R6).

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;
   typedef enum logic [1:0] {
      FN_CPL = 2'b00,
      FN_INC = 2'b01,
      FN_DEC = 2'b10,
      FN_DBL = 2'b11
   } alu_fn_e;
endpackage

// File: rtl/half_add_cell.sv
module half_add_cell (
   input  logic x,
   input  logic y,
   output logic s,
   output logic c
);
   assign s = x ^ y;
   assign c = x & y;
endmodule

// File: rtl/full_add_cell.sv
module full_add_cell (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic s0, c0, c1;
   half_add_cell u_ha0 (.x(x),  .y(y),  .s(s0), .c(c0));
   half_add_cell u_ha1 (.x(s0), .y(ci), .s(s),  .c(c1));
   assign co = c0 | c1;
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             ci,
   output logic [WIDTH-1:0] s,
   output logic             co
);
   logic [WIDTH:0] cc;
   assign cc[0] = ci;
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      full_add_cell u_fa (.x(x[i]), .y(y[i]), .ci(cc[i]), .s(s[i]), .co(cc[i+1]));
   end
   assign co = cc[WIDTH];

   // R2 R3 R4: the adder's carry chain agrees with a plain sum.
   always_comb begin
      if (!$isunknown({x, y, ci}))
         p_adder_sum_r2: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci}));
   end
endmodule

// File: rtl/inv_bank.sv
module inv_bank #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_inv
      assign q[i] = ~d[i];
   end
endmodule

// File: rtl/sel2.sv
module sel2 #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] d0,
   input  logic [WIDTH-1:0] d1,
   input  logic             s,
   output logic [WIDTH-1:0] q
);
   assign q = ({WIDTH{~s}} & d0) | ({WIDTH{s}} & d1);
endmodule

// File: rtl/sel4.sv
module sel4 #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] d0,
   input  logic [WIDTH-1:0] d1,
   input  logic [WIDTH-1:0] d2,
   input  logic [WIDTH-1:0] d3,
   input  logic [1:0]       s,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] lo, hi;
   sel2 #(.WIDTH(WIDTH)) u_lo  (.d0(d0), .d1(d1), .s(s[0]), .q(lo));
   sel2 #(.WIDTH(WIDTH)) u_hi  (.d0(d2), .d1(d3), .s(s[0]), .q(hi));
   sel2 #(.WIDTH(WIDTH)) u_out (.d0(lo), .d1(hi), .s(s[1]), .q(q));
endmodule

// File: rtl/sel_alu.sv
module sel_alu
   import sel_alu_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] opnd,
   input  logic [1:0]       func,
   output logic [WIDTH-1:0] res,
   output logic             carry
);
   localparam logic [WIDTH-1:0] K_ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] K_ALL1 = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] K_ZERO = '0;

   initial begin
      p_width_ok: assert (WIDTH >= 2)
         else $error("sel_alu: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] cpl_w, addend_w, sum_w;
   logic             co_w;
   logic [0:0]       carry_v;

   inv_bank #(.WIDTH(WIDTH)) u_inv (.d(opnd), .q(cpl_w));

   // The adder's second input: unused for code 00, one, all ones, or the operand.
   sel4 #(.WIDTH(WIDTH)) u_addend (
      .d0(K_ZERO), .d1(K_ONE), .d2(K_ALL1), .d3(opnd),
      .s(func), .q(addend_w)
   );

   ripple_adder #(.WIDTH(WIDTH)) u_add (
      .x(opnd), .y(addend_w), .ci(1'b0), .s(sum_w), .co(co_w)
   );

   sel4 #(.WIDTH(WIDTH)) u_result (
      .d0(cpl_w), .d1(sum_w), .d2(sum_w), .d3(sum_w),
      .s(func), .q(res)
   );

   sel2 #(.WIDTH(1)) u_carry (
      .d0(1'b0), .d1(co_w), .s(func[1] | func[0]), .q(carry_v)
   );
   assign carry = carry_v[0];

   always_comb begin
      if (!$isunknown({opnd, func})) begin
         if (func == FN_CPL) begin
            p_cpl_r1: assert (res == ~opnd && carry == 1'b0);
         end
         if (func == FN_INC) begin
            p_inc_r2: assert (res == opnd + K_ONE && carry == (opnd == K_ALL1));
         end
         if (func == FN_DEC) begin
            p_dec_r3: assert (res == opnd - K_ONE && carry == (opnd != K_ZERO));
         end
         if (func == FN_DBL) begin
            p_dbl_r4: assert (res == (opnd << 1) && carry == opnd[WIDTH-1]);
         end
      end
   end
endmodule

// File: tb/sel_alu_tb_top.sv
module sel_alu_tb_top;
   logic       clk = 1'b0;
   logic [3:0] opnd;
   logic [1:0] func;
   logic [3:0] res;
   logic       carry;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   always #5 clk = ~clk;

   sel_alu #(.WIDTH(4)) dut_i (.opnd(opnd), .func(func), .res(res), .carry(carry));

   task automatic apply(input logic [1:0] f, input logic [3:0] a,
                        input logic [3:0] er, input logic ec, input string req);
      @(posedge clk);
      #1;
      func = f;
      opnd = a;
      @(negedge clk);
      n_vec++;
      if (res !== er || carry !== ec) begin
         n_bad++;
         $display("FAIL %s func=%b opnd=%b: got res=%b carry=%b, expected res=%b carry=%b",
                  req, f, a, res, carry, er, ec);
      end
   endtask

   task automatic t_cpl_r1();
      for (int i = 0; i < 16; i++) apply(2'b00, 4'(i), ~4'(i), 1'b0, "R1");
   endtask

   task automatic t_inc_r2();
      for (int i = 0; i < 16; i++) apply(2'b01, 4'(i), 4'(i + 1), i == 15, "R2");
   endtask

   task automatic t_dec_r3();
      for (int i = 0; i < 16; i++) apply(2'b10, 4'(i), 4'(i + 15), i != 0, "R3");
   endtask

   task automatic t_dbl_r4();
      for (int i = 0; i < 16; i++) apply(2'b11, 4'(i), 4'(2 * i), (i >= 8), "R4");
   endtask

   task automatic t_wrap_r5();
      apply(2'b01, 4'b1111, 4'b0000, 1'b1, "R5");
      apply(2'b10, 4'b0000, 4'b1111, 1'b0, "R5");
      apply(2'b11, 4'b1000, 4'b0000, 1'b1, "R5");
   endtask

   // R6: change the code every vector; each result must ignore the previous input.
   task automatic t_mixed_r6();
      for (int i = 0; i < 16; i++) begin
         for (int f = 3; f >= 0; f--) begin
            logic [3:0] a, er;
            logic       ec;
            a = 4'(i * 7 + f);
            case (f)
               0: begin er = ~a;      ec = 1'b0;     end
               1: begin er = a + 4'd1; ec = (a == 4'hF); end
               2: begin er = a - 4'd1; ec = (a != 4'h0); end
               default: begin er = a << 1; ec = a[3]; end
            endcase
            apply(2'(f), a, er, ec, "R6");
         end
      end
   endtask

   initial begin
      opnd = 4'b0000;
      func = 2'b00;
      @(negedge clk);
      n_vec++;
      if (res !== 4'b1111 || carry !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 initial state: got res=%b carry=%b, expected res=1111 carry=0", res, carry);
      end
      t_cpl_r1();
      t_inc_r2();
      t_dec_r3();
      t_dbl_r4();
      t_wrap_r5();
      t_mixed_r6();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule